// File: doc/BRIEF.md
# Protected Program-Memory Access Controller

This block stands between an external programming station and a small on-chip program store while the device is in its programming and verification phase. A three-bit mode input picks one operation per transaction: write a code byte, read a code byte back, write a byte of the scramble key, set the first lock bit, set the second lock bit, or fetch one of two fixed identification bytes. Address and data come in on parallel inputs. An active-low program strobe is pulsed a fixed number of times to commit a write. Read data leaves on a registered byte output.

Readback is never plain once a key is loaded. The stored byte is combined by exclusive-NOR with one entry of a small key table, and the entry is picked by the address modulo the table size. The key table itself has no read path. Erased storage holds all ones, so an unloaded key leaves code readable as stored. Two lock bits tighten access step by step. The first freezes the code and key contents but still allows verification. The second also blanks verification to all ones.

Write sequencing is handled by a three-state machine. ST_IDLE latches the requested mode and moves to ST_COUNT when that mode is one of the four write modes (transition *arm*). ST_COUNT counts low-to-high strobe transitions. On the final one it issues a single-cycle commit and moves to ST_DONE (transition *fire*). If the mode changes before then, it returns to ST_IDLE and discards the count (transition *abort*). ST_DONE waits for the mode to change and then returns to ST_IDLE (transition *release*), so one transaction never commits twice.

Top module: `cguard_top`

## Requirements
- R1: After reset, data_o is 8'hFF, both lock bits are clear, and every code location reads back in verify mode as 8'hFF.
- R2: Mode encodings are 0 idle, 1 write code, 2 verify, 3 write key, 4 set lock 1, 5 set lock 2, 6 signature, 7 reserved. A write takes effect at the PULSES-th (default 25) low-to-high transition of strobe_i while a write mode is held. After PULSES-1 transitions the target is unchanged.
- R3: In verify mode, one clock edge after mode and address are presented, data_o equals ~(code[addr] ^ key[addr mod KEY_DEPTH]). With the key table erased (all 8'hFF), this is the stored code byte.
- R4: The key table has KEY_DEPTH entries (default 16). Addresses that differ by a multiple of KEY_DEPTH are descrambled with the same key entry, and a key write lands at entry addr mod KEY_DEPTH.
- R5: In every mode other than verify and signature, data_o is 8'hFF. No mode returns key table contents directly.
- R6: Once lock 1 is set, writes to code and to the key table are ignored, while verify keeps returning descrambled contents.
- R7: Lock 2 can still be set after lock 1. Once lock 2 is set, verify returns 8'hFF for every address. Lock bits never clear except by reset.
- R8: In signature mode, address 8'h30 returns SIG_BYTE0 (default 8'hC3) and address 8'h31 returns SIG_BYTE1 (default 8'h5E). Any other address returns 8'hFF. The lock bits do not affect this.
- R9: Leaving the write mode before the final strobe transition discards the partial count, and a new transaction starts counting from zero.
- R10: data_o is registered. A change of mode or address shows on data_o after exactly one rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Operation select (encoding in R2) |
| addr_i | input | ADDR_W | Location for code, key or signature access |
| data_i | input | 8 | Byte to be written |
| strobe_i | input | 1 | Active-low program pulse; counted on its rising edge |
| data_o | output | 8 | Registered read byte |

## Verification
The assertions assume that the address and write data stay steady for the whole of a strobe train, and that the mode changes only between transactions or as a deliberate abort. The frozen-content checks compare a location across consecutive cycles, so they rely on that steadiness. The bench drives every input at the falling clock edge and holds address, data and mode fixed from the first pulse to the last. It leaves the write mode only after the train is complete or at the point where it tests an abort. Because of this, each read sees one unambiguous address and mode.

// File: rtl/cguard_pkg.sv
package cguard_pkg;

    typedef enum logic [2:0] {
        MD_IDLE       = 3'd0,
        MD_PROG_CODE  = 3'd1,
        MD_VERIFY     = 3'd2,
        MD_PROG_KEY   = 3'd3,
        MD_PROG_LOCK1 = 3'd4,
        MD_PROG_LOCK2 = 3'd5,
        MD_SIGNATURE  = 3'd6,
        MD_RSVD       = 3'd7
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    function automatic logic is_write_mode(op_mode_e m);
        return (m == MD_PROG_CODE) || (m == MD_PROG_KEY) ||
               (m == MD_PROG_LOCK1) || (m == MD_PROG_LOCK2);
    endfunction

endpackage

// File: rtl/cguard_seq.sv
module cguard_seq
    import cguard_pkg::*;
#(
    parameter int PULSES = 25
) (
    input  logic     clk,
    input  logic     rst_n,
    input  op_mode_e mode_i,
    input  logic     strobe_i,
    output logic     commit_o,
    output op_mode_e target_o
);

    localparam int CNT_W = $clog2(PULSES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PULSES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    op_mode_e         lmode_q;
    logic             strb_q;
    logic             rise;
    logic             same_mode;

    assign rise      = strobe_i & ~strb_q;
    assign same_mode = (mode_i == lmode_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lmode_q <= MD_IDLE;
            strb_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            strb_q  <= strobe_i;
            if (state_q == ST_IDLE) begin
                cnt_q   <= '0;
                lmode_q <= mode_i;
            end else if (state_q == ST_COUNT && rise && cnt_q != LAST_CNT) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (is_write_mode(mode_i)) state_d = ST_COUNT;           // arm
            end
            ST_COUNT: begin
                if (!same_mode)                      state_d = ST_IDLE;  // abort
                else if (rise && cnt_q == LAST_CNT)  state_d = ST_DONE;  // fire
            end
            ST_DONE: begin
                if (!same_mode) state_d = ST_IDLE;                       // release
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit_o = 1'b0;
        target_o = lmode_q;
        unique case (state_q)
            ST_COUNT: commit_o = same_mode && rise && (cnt_q == LAST_CNT);
            ST_IDLE,
            ST_DONE:  commit_o = 1'b0;
            default:  commit_o = 1'b0;
        endcase
    end

    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT); // R2

    AST_COMMIT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (strobe_i && is_write_mode(mode_i))); // R2

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !same_mode) |=> (state_q == ST_IDLE && !commit_o)); // R9

endmodule

// File: rtl/cguard_store.sv
module cguard_store
    import cguard_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int KEY_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  op_mode_e          target_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic [7:0]        code_byte_o,
    output logic [7:0]        key_byte_o,
    output logic              lock1_o,
    output logic              lock2_o
);

    localparam int CODE_DEPTH = 1 << ADDR_W;
    localparam int KIDX_W     = (KEY_DEPTH > 1) ? $clog2(KEY_DEPTH) : 1;

    logic [7:0]        code_mem [CODE_DEPTH];
    logic [7:0]        key_mem  [KEY_DEPTH];
    logic [KIDX_W-1:0] kidx;
    logic              lock1_q, lock2_q;
    logic              code_we, key_we;

    assign kidx    = KIDX_W'(int'(addr_i) % KEY_DEPTH);
    assign code_we = commit_i && (target_i == MD_PROG_CODE) && !lock1_q;
    assign key_we  = commit_i && (target_i == MD_PROG_KEY)  && !lock1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CODE_DEPTH; i++) code_mem[i] <= ERASED_BYTE;
        end else if (code_we) begin
            code_mem[addr_i] <= data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < KEY_DEPTH; i++) key_mem[i] <= ERASED_BYTE;
        end else if (key_we) begin
            key_mem[kidx] <= data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock1_q <= 1'b0;
            lock2_q <= 1'b0;
        end else if (commit_i) begin
            if (target_i == MD_PROG_LOCK1) lock1_q <= 1'b1;
            if (target_i == MD_PROG_LOCK2) lock2_q <= 1'b1;
        end
    end

    assign code_byte_o = code_mem[addr_i];
    assign key_byte_o  = key_mem[kidx];
    assign lock1_o     = lock1_q;
    assign lock2_o     = lock2_q;

    AST_LOCK1_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && lock1_q && target_i == MD_PROG_CODE) |=>
        ((code_byte_o == $past(code_byte_o)) || (addr_i != $past(addr_i)))); // R6

    AST_LOCK1_KEY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && lock1_q && target_i == MD_PROG_KEY) |=>
        ((key_byte_o == $past(key_byte_o)) || (addr_i != $past(addr_i)))); // R6

    AST_LOCK1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock1_q |=> lock1_q); // R7

    AST_LOCK2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock2_q |=> lock2_q); // R7

endmodule

// File: rtl/cguard_readout.sv
module cguard_readout
    import cguard_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         SIG_ADDR  = 'h30,
    parameter logic [7:0] SIG_BYTE0 = 8'hC3,
    parameter logic [7:0] SIG_BYTE1 = 8'h5E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_mode_e          mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        code_byte_i,
    input  logic [7:0]        key_byte_i,
    input  logic              lock2_i,
    output logic [7:0]        data_o
);

    localparam logic [ADDR_W-1:0] SIG_LO = ADDR_W'(SIG_ADDR);
    localparam logic [ADDR_W-1:0] SIG_HI = ADDR_W'(SIG_ADDR + 1);

    logic [7:0] rd_d, rd_q;

    always_comb begin
        rd_d = ERASED_BYTE;
        unique case (mode_i)
            MD_VERIFY: begin
                if (!lock2_i) rd_d = ~(code_byte_i ^ key_byte_i);
            end
            MD_SIGNATURE: begin
                if (addr_i == SIG_LO)      rd_d = SIG_BYTE0;
                else if (addr_i == SIG_HI) rd_d = SIG_BYTE1;
            end
            default: rd_d = ERASED_BYTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= ERASED_BYTE;
        else        rd_q <= rd_d;
    end

    assign data_o = rd_q;

    AST_VERIFY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_VERIFY && lock2_i) |=> (data_o == ERASED_BYTE)); // R7

    AST_NO_READ_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MD_VERIFY && mode_i != MD_SIGNATURE) |=> (data_o == ERASED_BYTE)); // R5

    AST_SIG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_SIGNATURE && addr_i == SIG_LO) |=> (data_o == SIG_BYTE0)); // R8

endmodule

// File: rtl/cguard_top.sv
module cguard_top
    import cguard_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         KEY_DEPTH = 16,
    parameter int         PULSES    = 25,
    parameter int         SIG_ADDR  = 'h30,
    parameter logic [7:0] SIG_BYTE0 = 8'hC3,
    parameter logic [7:0] SIG_BYTE1 = 8'h5E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic              strobe_i,
    output logic [7:0]        data_o
);

    op_mode_e   mode;
    op_mode_e   target;
    logic       commit;
    logic [7:0] code_byte, key_byte;
    logic       lock1, lock2;

    assign mode = op_mode_e'(mode_i);

    cguard_seq #(
        .PULSES (PULSES)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .strobe_i (strobe_i),
        .commit_o (commit),
        .target_o (target)
    );

    cguard_store #(
        .ADDR_W    (ADDR_W),
        .KEY_DEPTH (KEY_DEPTH)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_i    (commit),
        .target_i    (target),
        .addr_i      (addr_i),
        .data_i      (data_i),
        .code_byte_o (code_byte),
        .key_byte_o  (key_byte),
        .lock1_o     (lock1),
        .lock2_o     (lock2)
    );

    cguard_readout #(
        .ADDR_W    (ADDR_W),
        .SIG_ADDR  (SIG_ADDR),
        .SIG_BYTE0 (SIG_BYTE0),
        .SIG_BYTE1 (SIG_BYTE1)
    ) readout_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .addr_i      (addr_i),
        .code_byte_i (code_byte),
        .key_byte_i  (key_byte),
        .lock2_i     (lock2),
        .data_o      (data_o)
    );

    AST_LOCK2_NEEDS_NO_LOCK1: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && target == MD_PROG_LOCK2) |=> lock2); // R7

endmodule

// File: tb/cguard_top_tb_top.sv
module cguard_top_tb_top;

    localparam int ADDR_W = 8;
    localparam int KDEP   = 16;
    localparam int NP     = 25;
    localparam int NADDR  = 1 << ADDR_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       mode = 3'd0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]       din = 8'h00;
    logic             strobe = 1'b1;
    logic [7:0]       dout;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] exp_code [NADDR];
    logic [7:0] exp_key  [KDEP];

    always #4 clk = ~clk;

    cguard_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .addr_i   (addr),
        .data_i   (din),
        .strobe_i (strobe),
        .data_o   (dout)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [2:0] m, input int a, output logic [7:0] v);
        @(negedge clk);
        mode = m;
        addr = ADDR_W'(a);
        @(negedge clk);
        v = dout;
    endtask

    task automatic write_op(input logic [2:0] m, input int a, input logic [7:0] d, input int n);
        @(negedge clk);
        mode = m;
        addr = ADDR_W'(a);
        din  = d;
        strobe = 1'b1;
        @(negedge clk);
        for (int p = 0; p < n; p++) begin
            strobe = 1'b0;
            @(negedge clk);
            strobe = 1'b1;
            @(negedge clk);
        end
        mode = 3'd0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] code_pat(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] key_pat(int i);
        return 8'(((i * 29) & 255) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] decoded(int a);
        return ~(exp_code[a] ^ exp_key[a % KDEP]);
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] prev;
        for (int i = 0; i < NADDR; i++) exp_code[i] = 8'hFF;
        for (int i = 0; i < KDEP; i++) exp_key[i] = 8'hFF;

        repeat (3) @(negedge clk);
        check("R1 reset data_o", dout, 8'hFF);
        rst_n = 1'b1;

        // R1: erased readout everywhere
        for (int a = 0; a < NADDR; a++) begin
            read_at(3'd2, a, v);
            check("R1 erased verify", v, 8'hFF);
        end

        // R2: one pulse short leaves the target untouched
        write_op(3'd1, 16, 8'h3C, NP - 1);
        read_at(3'd2, 16, v);
        check("R2 short train", v, 8'hFF);
        write_op(3'd1, 16, 8'h3C, NP);
        exp_code[16] = 8'h3C;
        read_at(3'd2, 16, v);
        check("R2 full train", v, 8'h3C);

        // R9: aborted train does not carry its count over
        write_op(3'd1, 32, 8'h77, 20);
        write_op(3'd1, 32, 8'h77, 10);
        read_at(3'd2, 32, v);
        check("R9 abort restart", v, 8'hFF);
        write_op(3'd1, 32, 8'h77, NP);
        exp_code[32] = 8'h77;
        read_at(3'd2, 32, v);
        check("R9 full after abort", v, 8'h77);

        // R3: plain readout with erased key table
        for (int a = 0; a < NADDR; a++) begin
            write_op(3'd1, a, code_pat(a), NP);
            exp_code[a] = code_pat(a);
        end
        for (int a = 0; a < NADDR; a++) begin
            read_at(3'd2, a, v);
            check("R3 plain readout", v, exp_code[a]);
        end

        // R4: key entries written at address mod depth (use high aliases)
        for (int i = 0; i < KDEP; i++) begin
            write_op(3'd3, i + 3 * KDEP, key_pat(i), NP);
            exp_key[i] = key_pat(i);
        end
        for (int a = 0; a < NADDR; a++) begin
            read_at(3'd2, a, v);
            check("R4 R3 scrambled readout", v, decoded(a));
        end

        // R10: one edge of latency
        read_at(3'd2, 5, prev);
        @(negedge clk);
        addr = ADDR_W'(6);
        #1;
        check("R10 before edge", dout, prev);
        @(negedge clk);
        check("R10 after edge", dout, decoded(6));

        // R5: non-read modes return all ones
        foreach (exp_key[i]) begin
            for (int m = 0; m < 8; m++) begin
                if (m != 2 && m != 6) begin
                    read_at(3'(m), i, v);
                    check("R5 non-read mode", v, 8'hFF);
                end
            end
        end

        // R8: signature
        read_at(3'd6, 'h30, v);
        check("R8 signature lo", v, 8'hC3);
        read_at(3'd6, 'h31, v);
        check("R8 signature hi", v, 8'h5E);
        read_at(3'd6, 'h32, v);
        check("R8 signature other", v, 8'hFF);

        // R6: lock 1 freezes code and key, verify still works
        write_op(3'd4, 0, 8'h00, NP);
        write_op(3'd1, 5, 8'h12, NP);
        write_op(3'd3, 0, 8'h34, NP);
        for (int a = 0; a < NADDR; a++) begin
            read_at(3'd2, a, v);
            check("R6 frozen after lock1", v, decoded(a));
        end

        // R7: lock 2 after lock 1 blanks verify
        write_op(3'd5, 0, 8'h00, NP);
        for (int a = 0; a < NADDR; a++) begin
            read_at(3'd2, a, v);
            check("R7 verify blocked", v, 8'hFF);
        end
        read_at(3'd6, 'h30, v);
        check("R8 signature under lock", v, 8'hC3);
        read_at(3'd6, 'h31, v);
        check("R8 signature under lock", v, 8'h5E);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule